// File: doc/BRIEF.md
# Operand Cache Array Access Port

This block gives software direct load/store access to the two storage arrays of a direct-mapped operand cache: the tag array, which holds one address tag and a valid and a dirty flag per line, and the data array, which holds eight 32-bit words per line. An access is presented with a single-cycle request strobe. A select input chooses the tag array or the data array. The port answers each request with a one-cycle completion pulse, and read data is valid in the same cycle as that pulse.

Replacing a tag through this port must not lose modified data. When software writes a tag entry in direct mode and the line it targets holds both the valid and the dirty flag, the port first pushes the line's eight data words out on a burst write master, one beat at a time in rising address order. Only after memory has accepted the last beat does the port install the new tag and flags and signal completion. A tag write with the associative selector bit set is accepted and completed but changes nothing. Normal cache lookup is handled elsewhere.

The number of lines is a parameter, 512 by default. Only one request may be outstanding at a time, so a new strobe may be issued only after the completion pulse of the previous one.

Top module: `ocache_array_port`

## Requirements
- R1: A tag-array entry reads back as a 32-bit word holding the tag in bits 28:10, the dirty flag in bit 1 and the valid flag in bit 0, with every other bit zero. A direct tag write keeps exactly those bits of the write data and drops the rest.
- R2: The line addressed by a tag access is taken from access address bits [IDX_W+4:5]. No other address bits choose the line.
- R3: A tag write with access address bit 3 set leaves the entry unchanged, starts no burst, and still completes.
- R4: A direct tag write (address bit 3 clear) to a line whose valid and dirty flags are both set first sends exactly eight burst beats, with beat offsets 0 through 7 in ascending order, and `wb_last` high only on offset 7. Completion and the tag update come only after the eighth beat has been accepted.
- R5: The address of writeback beat b is {3'b000, stored tag bits 28:10, line index bits 4:0, b[2:0], 2'b00}. The tag used is the one installed by the previous direct write. Its data is the line's data-array word b as it stands when the burst starts.
- R6: A direct tag write to a line that is not both valid and dirty replaces the entry without any burst.
- R7: A data-array access reads or writes the 32-bit word numbered by access address bits [IDX_W+4:2], which is line index times eight plus word offset. Data writes leave the tag array untouched.
- R8: Reset clears every line's valid and dirty flags, and leaves `acc_done` and `wb_valid` low.
- R9: While a beat is offered and `wb_ready` is low, `wb_valid`, `wb_addr` and `wb_data` hold their values.
- R10: Every request produces exactly one single-cycle `acc_done` pulse, and the pulse never coincides with an offered beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | One-cycle request strobe, honoured while the port is idle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_data_sel | input | 1 | 1 = data array, 0 = tag array |
| acc_addr | input | 32 | Access address (line, word offset, associative bit 3) |
| acc_wdata | input | 32 | Write data |
| acc_done | output | 1 | Completion pulse, one cycle per request |
| acc_rdata | output | 32 | Read result, valid while `acc_done` is high |
| wb_valid | output | 1 | Writeback beat offered |
| wb_addr | output | 32 | Byte address of the offered beat |
| wb_data | output | 32 | Data of the offered beat |
| wb_last | output | 1 | Offered beat is the eighth of its burst |
| wb_ready | input | 1 | Memory accepts the offered beat this cycle |

## Verification
The bench builds the port with IDX_W = 5, which gives 32 lines and 256 data words. With that size every tag entry and every data word can be written and read back in each pass, so each flag combination meets each line. Several full rewrite passes run, some with `wb_ready` throttled, and every writeback burst is compared beat by beat against a model. That model takes the previously installed tag and the current data words as the expected address and data.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_WB_RD,
    ST_WB_SEND,
    ST_COMMIT
  } ocp_state_e;

  localparam int TAG_HI    = 28;
  localparam int TAG_LO    = 10;
  localparam int TAG_W     = TAG_HI - TAG_LO + 1;
  localparam int BEATS     = 8;
  localparam int BEAT_W    = $clog2(BEATS);
  localparam int KEY_IDX_W = 5;

  function automatic logic [31:0] pack_entry(input logic [TAG_W-1:0] tag,
                                             input logic dirty,
                                             input logic valid);
    return {3'b000, tag, 8'h00, dirty, valid};
  endfunction
endpackage

// File: rtl/ocp_tag_store.sv
module ocp_tag_store
  import ocp_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid,
  input  logic             wr_dirty
);
  localparam int LINES = 1 << IDX_W;

  // tag bits live in RAM; flags live in flops so reset can clear them at once
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_v;
  logic [LINES-1:0] dirty_v;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_v <= '0;
      dirty_v <= '0;
    end else if (wr_en) begin
      valid_v[wr_idx] <= wr_valid;
      dirty_v[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_dirty <= 1'b0;
    end else if (rd_en) begin
      rd_valid <= valid_v[rd_idx];
      rd_dirty <= dirty_v[rd_idx];
    end
  end
endmodule

// File: rtl/ocp_data_store.sv
module ocp_data_store #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [31:0] mem [DEPTH];

  // single port, read-first
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/ocache_array_port.sv
module ocache_array_port
  import ocp_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_req,
  input  logic        acc_write,
  input  logic        acc_data_sel,
  input  logic [31:0] acc_addr,
  input  logic [31:0] acc_wdata,
  output logic        acc_done,
  output logic [31:0] acc_rdata,
  output logic        wb_valid,
  output logic [31:0] wb_addr,
  output logic [31:0] wb_data,
  output logic        wb_last,
  input  logic        wb_ready
);
  localparam int WADDR_W = IDX_W + BEAT_W;
  localparam int ADDR_HI = IDX_W + 4;

  ocp_state_e         state;
  logic               write_q, dsel_q, assoc_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WADDR_W-1:0] word_q;
  logic [31:0]        wdata_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [TAG_W-1:0]   old_tag_q;

  logic               accept;
  logic [IDX_W-1:0]   acc_idx;
  logic [WADDR_W-1:0] acc_word;
  logic               unused_addr_bits;

  logic [TAG_W-1:0]   rd_tag;
  logic               rd_valid, rd_dirty;
  logic               tag_wr_en, direct_tag_wr, line_dirty;

  logic               d_en, d_we;
  logic [WADDR_W-1:0] d_addr;
  logic [31:0]        d_q;

  assign accept   = (state == ST_IDLE) && acc_req;
  assign acc_idx  = acc_addr[ADDR_HI:5];
  assign acc_word = acc_addr[ADDR_HI:2];
  assign unused_addr_bits = ^{acc_addr[31:ADDR_HI+1], acc_addr[1:0]};

  assign direct_tag_wr = write_q && !dsel_q && !assoc_q;
  assign line_dirty    = rd_valid && rd_dirty;
  assign tag_wr_en     = ((state == ST_EXEC) && direct_tag_wr && !line_dirty)
                       || (state == ST_COMMIT);

  ocp_tag_store #(.IDX_W(IDX_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (accept),
    .rd_idx   (acc_idx),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .wr_en    (tag_wr_en),
    .wr_idx   (idx_q),
    .wr_tag   (wdata_q[TAG_HI:TAG_LO]),
    .wr_valid (wdata_q[0]),
    .wr_dirty (wdata_q[1])
  );

  always_comb begin
    d_en   = accept;
    d_we   = 1'b0;
    d_addr = acc_word;
    if (state == ST_WB_RD) begin
      d_en   = 1'b1;
      d_addr = {idx_q, beat_q};
    end else if ((state == ST_EXEC) && dsel_q && write_q) begin
      d_en   = 1'b1;
      d_we   = 1'b1;
      d_addr = word_q;
    end
  end

  ocp_data_store #(.ADDR_W(WADDR_W)) u_data (
    .clk   (clk),
    .en    (d_en),
    .we    (d_we),
    .addr  (d_addr),
    .wdata (wdata_q),
    .q     (d_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      acc_done  <= 1'b0;
      acc_rdata <= '0;
      beat_q    <= '0;
      write_q   <= 1'b0;
      dsel_q    <= 1'b0;
      assoc_q   <= 1'b0;
      idx_q     <= '0;
      word_q    <= '0;
      wdata_q   <= '0;
      old_tag_q <= '0;
    end else begin
      acc_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (acc_req) begin
            write_q <= acc_write;
            dsel_q  <= acc_data_sel;
            assoc_q <= acc_addr[3];
            idx_q   <= acc_idx;
            word_q  <= acc_word;
            wdata_q <= acc_wdata;
            state   <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (!write_q) begin
            acc_rdata <= dsel_q ? d_q : pack_entry(rd_tag, rd_dirty, rd_valid);
          end
          if (direct_tag_wr && line_dirty) begin
            old_tag_q <= rd_tag;
            beat_q    <= '0;
            state     <= ST_WB_RD;
          end else begin
            acc_done <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_WB_RD: state <= ST_WB_SEND;
        ST_WB_SEND: begin
          if (wb_ready) begin
            if (beat_q == BEAT_W'(BEATS - 1)) begin
              state <= ST_COMMIT;
            end else begin
              beat_q <= beat_q + 1'b1;
              state  <= ST_WB_RD;
            end
          end
        end
        ST_COMMIT: begin
          acc_done <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wb_valid = (state == ST_WB_SEND);
  assign wb_addr  = {3'b000, old_tag_q, idx_q[KEY_IDX_W-1:0], beat_q, 2'b00};
  assign wb_data  = d_q;
  assign wb_last  = wb_valid && (beat_q == BEAT_W'(BEATS - 1));
endmodule

// File: rtl/ocp_checker.sv
module ocp_checker (
  input logic        clk,
  input logic        rst,
  input logic        acc_done,
  input logic        wb_valid,
  input logic [31:0] wb_addr,
  input logic [31:0] wb_data,
  input logic        wb_last,
  input logic        wb_ready
);
  logic [2:0] exp_beat;

  always_ff @(posedge clk) begin
    if (rst) exp_beat <= '0;
    else if (wb_valid && wb_ready) exp_beat <= wb_last ? 3'd0 : exp_beat + 3'd1;
  end

  a_r9_hold_beat: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

  a_r4_beat_order: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_addr[4:2] == exp_beat);

  a_r4_last_on_eighth: assert property (@(posedge clk) disable iff (rst)
    wb_valid && wb_ready && wb_last |-> exp_beat == 3'd7);

  a_r4_no_done_mid_burst: assert property (@(posedge clk) disable iff (rst)
    exp_beat != 3'd0 |-> !acc_done);

  a_r5_addr_shape: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_addr[1:0] == 2'b00 && wb_addr[31:29] == 3'b000);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    acc_done |=> !acc_done);

  a_r10_done_apart: assert property (@(posedge clk) disable iff (rst)
    acc_done |-> !wb_valid);
endmodule

bind ocache_array_port ocp_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_done (acc_done),
  .wb_valid (wb_valid),
  .wb_addr  (wb_addr),
  .wb_data  (wb_data),
  .wb_last  (wb_last),
  .wb_ready (wb_ready)
);

// File: tb/tb_ocache_array_port.sv
module tb_ocache_array_port;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 5;
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = LINES * 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_req = 1'b0, acc_write = 1'b0, acc_data_sel = 1'b0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic        acc_done;
  logic [31:0] acc_rdata;
  logic        wb_valid, wb_last;
  logic [31:0] wb_addr, wb_data;
  logic        wb_ready = 1'b1;

  int tests = 0;
  int fails = 0;
  int tick  = 0;
  bit stall = 1'b0;

  logic [31:0] exp_tag  [LINES];
  logic [31:0] exp_data [WORDS];
  logic [31:0] bt_addr [8];
  logic [31:0] bt_data [8];
  logic        bt_last [8];

  ocache_array_port #(.IDX_W(IDX_W)) dut (
    .clk, .rst, .acc_req, .acc_write, .acc_data_sel, .acc_addr, .acc_wdata,
    .acc_done, .acc_rdata, .wb_valid, .wb_addr, .wb_data, .wb_last, .wb_ready
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic sel, input logic wr, input logic [31:0] addr,
                        input logic [31:0] wdata, output logic [31:0] rd, output int nb);
    @(negedge clk);
    acc_req = 1'b1; acc_data_sel = sel; acc_write = wr;
    acc_addr = addr; acc_wdata = wdata;
    @(negedge clk);
    acc_req = 1'b0;
    nb = 0;
    while (!acc_done) begin
      tick++;
      wb_ready = stall ? ((tick % 3) != 0) : 1'b1;
      if (wb_valid && wb_ready) begin
        if (nb < 8) begin
          bt_addr[nb] = wb_addr; bt_data[nb] = wb_data; bt_last[nb] = wb_last;
        end
        nb++;
      end
      @(negedge clk);
    end
    rd = acc_rdata;
    @(negedge clk);
    chk("R10", "done is one cycle", {31'd0, acc_done}, 32'd0);
  endtask

  function automatic logic [31:0] tag_word(input int i, input int pass);
    logic [18:0] t;
    logic [1:0]  f;
    t = 19'(i * 977 + pass * 12345 + 7);
    f = 2'((i + pass) % 4);
    return {3'b101, t, 8'hA5, f};
  endfunction

  function automatic logic [31:0] data_word(input int w, input int pass);
    return (32'h1000_0001 * 32'(w + 1)) ^ 32'(pass * 32'h0BAD_0000) ^ 32'h5A5A_0000;
  endfunction

  task automatic rewrite_pass(input int pass);
    logic [31:0] rd, nv;
    int nb;
    for (int i = 0; i < LINES; i++) begin
      stall = (i % 2) == 1;
      nv = tag_word(i, pass);
      access(1'b0, 1'b1, 32'(i) << 5, nv, rd, nb);
      if (exp_tag[i][1:0] == 2'b11) begin
        chk("R4", "burst beat count", 32'(nb), 32'd8);
        for (int b = 0; b < 8; b++) begin
          chk("R5", "beat address", bt_addr[b],
              {3'b000, exp_tag[i][28:10], 5'(i), 3'(b), 2'b00});
          chk("R5", "beat data", bt_data[b], exp_data[i * 8 + b]);
          chk("R4", "last flag", {31'd0, bt_last[b]}, {31'd0, b == 7});
        end
      end else begin
        chk("R6", "no burst on clean line", 32'(nb), 32'd0);
      end
      exp_tag[i] = nv & 32'h1FFF_FC03;
    end
    stall = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      access(1'b0, 1'b0, 32'(i) << 5, 32'h0, rd, nb);
      chk("R4", "tag replaced after write", rd, exp_tag[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int nb;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R8", "done low after reset", {31'd0, acc_done}, 32'd0);
    chk("R8", "wb_valid low after reset", {31'd0, wb_valid}, 32'd0);

    // R8: every line reads back invalid and clean
    for (int i = 0; i < LINES; i++) begin
      access(1'b0, 1'b0, 32'(i) << 5, 32'h0, rd, nb);
      chk("R8", "flags cleared", {30'd0, rd[1:0]}, 32'd0);
    end

    // R7: fill and read back the whole data array; high address bits are noise
    for (int w = 0; w < WORDS; w++) begin
      exp_data[w] = data_word(w, 0);
      access(1'b1, 1'b1, 32'hF400_0000 | (32'(w) << 2) | 32'h3, exp_data[w], rd, nb);
    end
    for (int w = 0; w < WORDS; w++) begin
      access(1'b1, 1'b0, (32'(w) << 2) | 32'h0000_0C00, 32'h0, rd, nb);
      chk("R7", "data word readback", rd, exp_data[w]);
    end

    // R1 R2 R6: first tag pass on invalid lines, bits outside the index are set
    for (int i = 0; i < LINES; i++) begin
      exp_tag[i] = tag_word(i, 0) & 32'h1FFF_FC03;
      access(1'b0, 1'b1, 32'h0000_F814 | (32'(i) << 5), tag_word(i, 0), rd, nb);
      chk("R6", "no burst on invalid line", 32'(nb), 32'd0);
    end
    for (int i = 0; i < LINES; i++) begin
      access(1'b0, 1'b0, 32'(i) << 5, 32'h0, rd, nb);
      chk("R1", "masked tag entry", rd, exp_tag[i]);
      chk("R2", "line selected by index", rd[28:10] == 19'(i * 977 + 7) ? 32'd1 : 32'd0, 32'd1);
    end

    // R3: associative writes change nothing, even on dirty lines
    for (int i = 0; i < LINES; i++) begin
      access(1'b0, 1'b1, (32'(i) << 5) | 32'h8, 32'hFFFF_FFFF, rd, nb);
      chk("R3", "no burst in associative mode", 32'(nb), 32'd0);
      access(1'b0, 1'b0, 32'(i) << 5, 32'h0, rd, nb);
      chk("R3", "entry unchanged", rd, exp_tag[i]);
    end

    // R4 R5 R9: rewrite passes with and without throttled wb_ready
    rewrite_pass(1);
    for (int w = 0; w < WORDS; w += 3) begin
      exp_data[w] = data_word(w, 2);
      access(1'b1, 1'b1, 32'(w) << 2, exp_data[w], rd, nb);
    end
    for (int i = 0; i < LINES; i++) begin
      access(1'b0, 1'b0, 32'(i) << 5, 32'h0, rd, nb);
      chk("R7", "data write leaves tags", rd, exp_tag[i]);
    end
    rewrite_pass(2);
    rewrite_pass(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule